// File: doc/BRIEF.md
# Rolling-Shutter Frame Sequencer

This block sets the frame timing of a rolling-shutter image sensor. It decides when the sensor's line pointer returns to the first line, when a frame is read out, and whether that readout is forwarded downstream as valid video. It also drives a shutter or strobe output that frames the exposure window. The frame readout time is modelled as a line counter: `NUM_LINES` lines of `LINE_CYCLES` clocks each. The shutter time is counted in steps of `STEP_CYCLES` clocks.

Four synchronisation modes exist. Free-run reads valid frames continuously, with an optional shutter pause between them. Three trigger-driven modes wait for a qualified trigger. While they wait, they keep the sensor clear with dummy readouts whose frame-valid flag stays low. When a trigger arrives, each mode runs its own sequence of dummy frame, shutter window and valid frame. The trigger comes from one of two inputs. It is resynchronised, given a programmable polarity, and filtered against pulses that are too short.

Top module: `rs_frame_sequencer`

## Requirements
- R1: While reset is asserted, `read_act_o`, `fval_o`, `ptr_rst_o` and `wait_trig_o` are low, and `shutter_o` equals `shut_neg_i` (the inactive level). The sequencer leaves its idle state in the third clock after reset is released.
- R2: With mode code 3'b000 (free-run) and a shutter count of zero, valid frames follow back to back. `fval_o` stays high, and `ptr_rst_o` pulses for one cycle at the first cycle of every frame, every `NUM_LINES*LINE_CYCLES` cycles.
- R3: In free-run with a nonzero shutter count N, readout pauses after each frame for N*`STEP_CYCLES` cycles. During the pause `read_act_o` and `fval_o` are low and the shutter is active. The next valid frame starts in the cycle the shutter ends.
- R4: In modes 3'b001, 3'b010 and 3'b011 with no trigger, the block keeps reading dummy frames, with `read_act_o` high and `fval_o` low, and holds `wait_trig_o` high.
- R5: An accepted trigger while waiting aborts the dummy frame in progress and drops `wait_trig_o`. In mode 3'b001, a new readout starts from line 1 (`ptr_rst_o` high) `MIN_PULSE+2` cycles after the trigger input first reaches its active level before a clock edge.
- R6: Mode 3'b001 runs one full dummy frame, then the shutter window for N steps, then one valid frame, then returns to waiting. When N is zero the shutter window is skipped.
- R7: Mode 3'b010 skips the dummy frame. The trigger leads straight to the shutter window and then to one valid frame.
- R8: In mode 3'b011 the shutter becomes active together with trigger acceptance. It stays active until 2 cycles after the synchronised trigger returns inactive. The valid frame starts in the cycle the shutter ends.
- R9: A trigger arriving during the shutter window or the valid frame has no effect.
- R10: The trigger is accepted only after its active level has been seen for `MIN_PULSE` consecutive synchronised samples. A shorter pulse has no effect. A held level gives one trigger only.
- R11: `trig_src_i` = 0 selects `trig_a_i` and 1 selects `trig_b_i`. The unselected input has no effect.
- R12: `trig_neg_i` = 1 makes the trigger active low, so a falling edge starts the sequence.
- R13: `shut_neg_i` = 1 inverts `shutter_o`, which is then low while the shutter window is open.
- R14: Mode codes with bit 2 set are reserved. In these modes there is no readout, no shutter window and no waiting status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Synchronisation mode code |
| trig_src_i | input | 1 | Trigger input select |
| trig_neg_i | input | 1 | Trigger active low when 1 |
| shut_neg_i | input | 1 | Shutter output active low when 1 |
| shut_steps_i | input | SHUT_W | Shutter time in steps |
| trig_a_i | input | 1 | Trigger input A (asynchronous) |
| trig_b_i | input | 1 | Trigger input B (asynchronous) |
| ptr_rst_o | output | 1 | Line pointer return to line 1, first cycle of each readout |
| read_act_o | output | 1 | Sensor readout in progress |
| fval_o | output | 1 | Readout is a valid frame |
| shutter_o | output | 1 | Shutter/strobe output |
| wait_trig_o | output | 1 | Idle and waiting for a trigger |

## Verification
A corrupted sequencer state shows up as a misplaced edge on frame-valid, shutter or waiting status. In the worst case the edge moves by a whole frame time, because an extra or missing dummy frame moves the later edges by exactly `NUM_LINES*LINE_CYCLES` cycles. A counter error moves the shutter or frame-valid edge by a single cycle, and that shows at the first window after the fault. A filter or synchroniser fault shows as a sequence start that is late, early or missing, a fixed number of cycles after the trigger stimulus. For this reason every output edge is compared at its exact expected cycle.

// File: rtl/rsseq_pkg.sv
package rsseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_PRE   = 3'd2,
    ST_SHUT  = 3'd3,
    ST_GATE  = 3'd4,
    ST_VALID = 3'd5
  } seq_state_e;

  localparam logic [2:0] MODE_FREE    = 3'b000;
  localparam logic [2:0] MODE_TRIG    = 3'b001;
  localparam logic [2:0] MODE_TRIG_NR = 3'b010;
  localparam logic [2:0] MODE_ITC     = 3'b011;

  function automatic logic is_trig_mode(input logic [2:0] m);
    return (m == MODE_TRIG) || (m == MODE_TRIG_NR) || (m == MODE_ITC);
  endfunction

  function automatic logic is_readout(input seq_state_e s);
    return (s == ST_WAIT) || (s == ST_PRE) || (s == ST_VALID);
  endfunction

endpackage

// File: rtl/rsseq_trig_qual.sv
module rsseq_trig_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_a_i,
  input  logic trig_b_i,
  input  logic src_i,
  input  logic neg_i,
  output logic evt_o,
  output logic lvl_o
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);

  logic [1:0]       sync_q [SYNC_STAGES];
  logic             active;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {trig_b_i, trig_a_i};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign active = (src_i ? sync_q[SYNC_STAGES-1][1] : sync_q[SYNC_STAGES-1][0]) ^ neg_i;

  // Qualification: an event fires once the active level has lasted MIN_PULSE samples,
  // and only after an inactive sample has re-armed the detector.
  always_comb begin
    evt_o = armed_q && active && (cnt_q == CNT_W'(MIN_PULSE - 1));
    lvl_o = active && (cnt_q >= CNT_W'(MIN_PULSE - 1));
    if (!active)                           cnt_d = '0;
    else if (cnt_q == CNT_W'(MIN_PULSE))   cnt_d = cnt_q;
    else                                   cnt_d = cnt_q + 1'b1;
    if (!active)    armed_d = 1'b1;
    else if (evt_o) armed_d = 1'b0;
    else            armed_d = armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  p_evt_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);

  generate
    if (MIN_PULSE > 1) begin : g_prev_chk
      p_evt_prev_active_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |-> $past(active));
    end
  endgenerate

endmodule

// File: rtl/rsseq_frame_timer.sv
module rsseq_frame_timer #(
  parameter int LINE_CYCLES = 1400,
  parameter int NUM_LINES   = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic start_o,
  output logic last_o
);
  localparam int CYC_W  = (LINE_CYCLES > 1) ? $clog2(LINE_CYCLES) : 1;
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [CYC_W-1:0]  cyc_q, cyc_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              line_end;

  assign line_end = (cyc_q == CYC_W'(LINE_CYCLES - 1));
  assign start_o  = run_i && (cyc_q == '0) && (line_q == '0);
  assign last_o   = run_i && line_end && (line_q == LINE_W'(NUM_LINES - 1));

  always_comb begin
    cyc_d  = cyc_q;
    line_d = line_q;
    if (!run_i || restart_i || last_o) begin
      cyc_d  = '0;
      line_d = '0;
    end else if (line_end) begin
      cyc_d  = '0;
      line_d = line_q + 1'b1;
    end else begin
      cyc_d  = cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      line_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      line_q <= line_d;
    end
  end

  p_wrap_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && $past(last_o) |-> start_o);

  p_restart_line1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(restart_i) |-> start_o);

endmodule

// File: rtl/rsseq_expo_timer.sv
module rsseq_expo_timer #(
  parameter int STEP_CYCLES = 1000,
  parameter int STEPS_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [STEPS_W-1:0] steps_i,
  output logic               done_o
);
  localparam int SUB_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

  logic [SUB_W-1:0]   sub_q, sub_d;
  logic [STEPS_W-1:0] cnt_q, cnt_d;
  logic [STEPS_W-1:0] steps_q, steps_d;
  logic               step_end;

  assign step_end = (sub_q == SUB_W'(STEP_CYCLES - 1));
  assign done_o   = run_i && step_end && (cnt_q == steps_q - 1'b1);

  always_comb begin
    sub_d   = sub_q;
    cnt_d   = cnt_q;
    steps_d = steps_q;
    if (!run_i) begin
      sub_d   = '0;
      cnt_d   = '0;
      steps_d = steps_i;
    end else if (step_end) begin
      sub_d = '0;
      cnt_d = cnt_q + 1'b1;
    end else begin
      sub_d = sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q   <= '0;
      cnt_q   <= '0;
      steps_q <= '0;
    end else begin
      sub_q   <= sub_d;
      cnt_q   <= cnt_d;
      steps_q <= steps_d;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/rs_frame_sequencer.sv
module rs_frame_sequencer
  import rsseq_pkg::*;
#(
  parameter int LINE_CYCLES = 1400,
  parameter int NUM_LINES   = 1024,
  parameter int STEP_CYCLES = 1000,
  parameter int MIN_PULSE   = 100,
  parameter int SHUT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              trig_src_i,
  input  logic              trig_neg_i,
  input  logic              shut_neg_i,
  input  logic [SHUT_W-1:0] shut_steps_i,
  input  logic              trig_a_i,
  input  logic              trig_b_i,
  output logic              ptr_rst_o,
  output logic              read_act_o,
  output logic              fval_o,
  output logic              shutter_o,
  output logic              wait_trig_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  seq_state_e state_q, state_d, after_frame;
  logic       trig_evt, trig_lvl;
  logic       frame_start, frame_last, expo_done;
  logic       abort, mode_free, mode_trig, steps_nz, shutter_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rsseq_trig_qual #(.SYNC_STAGES(2), .MIN_PULSE(MIN_PULSE)) u_trig (
    .clk_i(clk_i), .rst_ni(rst_int_n),
    .trig_a_i(trig_a_i), .trig_b_i(trig_b_i),
    .src_i(trig_src_i), .neg_i(trig_neg_i),
    .evt_o(trig_evt), .lvl_o(trig_lvl)
  );

  rsseq_frame_timer #(.LINE_CYCLES(LINE_CYCLES), .NUM_LINES(NUM_LINES)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_int_n),
    .run_i(is_readout(state_q)), .restart_i(abort),
    .start_o(frame_start), .last_o(frame_last)
  );

  rsseq_expo_timer #(.STEP_CYCLES(STEP_CYCLES), .STEPS_W(SHUT_W)) u_expo (
    .clk_i(clk_i), .rst_ni(rst_int_n),
    .run_i(state_q == ST_SHUT), .steps_i(shut_steps_i),
    .done_o(expo_done)
  );

  assign mode_free = (mode_i == MODE_FREE);
  assign mode_trig = is_trig_mode(mode_i);
  assign steps_nz  = |shut_steps_i;

  always_comb begin
    if (mode_free)      after_frame = steps_nz ? ST_SHUT : ST_VALID;
    else if (mode_trig) after_frame = ST_WAIT;
    else                after_frame = ST_IDLE;
  end

  always_comb begin
    state_d = state_q;
    abort   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (mode_free)      state_d = ST_VALID;
        else if (mode_trig) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mode_trig && trig_evt) begin
          abort = 1'b1;
          if (mode_i == MODE_TRIG)         state_d = ST_PRE;
          else if (mode_i == MODE_TRIG_NR) state_d = steps_nz ? ST_SHUT : ST_VALID;
          else                             state_d = ST_GATE;
        end else if (frame_last) begin
          state_d = after_frame;
        end
      end
      ST_PRE:   if (frame_last) state_d = steps_nz ? ST_SHUT : ST_VALID;
      ST_SHUT:  if (expo_done)  state_d = ST_VALID;
      ST_GATE:  if (!trig_lvl)  state_d = ST_VALID;
      ST_VALID: if (frame_last) state_d = after_frame;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  assign shutter_act = (state_q == ST_SHUT) || (state_q == ST_GATE);
  assign read_act_o  = is_readout(state_q);
  assign fval_o      = (state_q == ST_VALID);
  assign wait_trig_o = (state_q == ST_WAIT);
  assign ptr_rst_o   = frame_start;
  assign shutter_o   = shutter_act ^ shut_neg_i;

  p_wait_dummy_r4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    wait_trig_o |-> read_act_o && !fval_o);

  p_shut_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (state_q == ST_SHUT) && !expo_done |=> (state_q == ST_SHUT));

  p_reserved_idle_r14: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    mode_i[2] && (state_q == ST_IDLE) |=> (state_q == ST_IDLE));

  p_valid_after_shut_r6: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $fell(shutter_act) |-> fval_o);

endmodule

// File: tb/rs_frame_sequencer_tb_top.sv
module rs_frame_sequencer_tb_top;

  typedef struct {
    int    cyc;
    int    sig;
    logic  val;
    string req;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [2:0]  mode;
  logic        trig_src, trig_neg, shut_neg;
  logic [15:0] steps;
  logic        trig_a, trig_b;
  logic        ptr_rst, read_act, fval, shutter, wait_trig;

  int    cyc = 0;
  int    base = 0;
  logic  mon_en = 1'b0;
  logic  finished = 1'b0;
  string cur_req = "R1";
  exp_t  sb_q[$];
  int    mon_checks = 0, mon_fails = 0;
  int    drv_checks = 0, drv_fails = 0;
  int    wd_fails = 0;
  logic [2:0] prev = '0;

  rs_frame_sequencer #(
    .LINE_CYCLES(4), .NUM_LINES(4), .STEP_CYCLES(5), .MIN_PULSE(3), .SHUT_W(16)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .trig_src_i(trig_src), .trig_neg_i(trig_neg), .shut_neg_i(shut_neg),
    .shut_steps_i(steps), .trig_a_i(trig_a), .trig_b_i(trig_b),
    .ptr_rst_o(ptr_rst), .read_act_o(read_act), .fval_o(fval),
    .shutter_o(shutter), .wait_trig_o(wait_trig)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rel();
    return cyc - base;
  endfunction

  // Monitor: every change of fval(0), shutter(1), wait(2) must match the queue head.
  always @(negedge clk) begin
    logic [2:0] cur;
    cur = {wait_trig, shutter, fval};
    if (mon_en) begin
      for (int s = 0; s < 3; s++) begin
        if (cur[s] !== prev[s]) begin
          mon_checks++;
          if (sb_q.size() == 0) begin
            mon_fails++;
            $display("FAIL %s: output %0d changed to %0b at cycle %0d, expected no change",
                     cur_req, s, cur[s], rel());
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.cyc != rel() || e.sig != s || e.val !== cur[s]) begin
              mon_fails++;
              $display("FAIL %s: actual output %0d -> %0b at cycle %0d, expected output %0d -> %0b at cycle %0d",
                       e.req, s, cur[s], rel(), e.sig, e.val, e.cyc);
            end
          end
        end
      end
    end
    prev = cur;
  end

  task automatic push(input int c, input int s, input logic v, input string req);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    drv_checks++;
    if (act !== exp) begin
      drv_fails++;
      $display("FAIL %s: %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, rel());
    end
  endtask

  task automatic wait_rel(input int n);
    while (rel() < n) @(negedge clk);
  endtask

  task automatic start_run(input logic [2:0] m, input logic src, input logic tneg,
                           input logic sneg, input logic [15:0] st,
                           input logic a0, input logic b0, input string req);
    @(negedge clk);
    rst_n = 1'b0; mon_en = 1'b0; sb_q.delete();
    mode = m; trig_src = src; trig_neg = tneg; shut_neg = sneg; steps = st;
    trig_a = a0; trig_b = b0; cur_req = req;
    repeat (3) @(negedge clk);
    chk("R1", "read_act in reset", read_act, 1'b0);
    chk("R1", "fval in reset", fval, 1'b0);
    chk("R1", "ptr_rst in reset", ptr_rst, 1'b0);
    chk("R1", "wait_trig in reset", wait_trig, 1'b0);
    chk("R1", "shutter idle level in reset", shutter, sneg);
    rst_n = 1'b1; base = cyc; mon_en = 1'b1;
  endtask

  task automatic end_run(input string req);
    drv_checks++;
    if (sb_q.size() != 0) begin
      drv_fails++;
      $display("FAIL %s: %0d expected output changes missing, next at cycle %0d, expected 0 pending",
               req, sb_q.size(), sb_q[0].cyc);
    end
  endtask

  initial begin
    rst_n = 1'b0; mode = 3'b000; trig_src = 1'b0; trig_neg = 1'b0; shut_neg = 1'b0;
    steps = '0; trig_a = 1'b0; trig_b = 1'b0;

    // R2: free-run, shutter count zero, back-to-back valid frames
    start_run(3'b000, 0, 0, 0, 16'd0, 0, 0, "R2");
    push(3, 0, 1'b1, "R2");
    wait_rel(2);  chk("R1", "still idle two cycles after release", read_act, 1'b0);
    wait_rel(3);  chk("R2", "ptr_rst at first frame", ptr_rst, 1'b1);
    wait_rel(4);  chk("R2", "ptr_rst one-cycle", ptr_rst, 1'b0);
    wait_rel(19); chk("R2", "ptr_rst at second frame", ptr_rst, 1'b1);
    wait_rel(35); chk("R2", "ptr_rst at third frame", ptr_rst, 1'b1);
    chk("R2", "fval stays high", fval, 1'b1);
    wait_rel(40); end_run("R2");

    // R3: free-run with 2 steps of shutter between frames
    start_run(3'b000, 0, 0, 0, 16'd2, 0, 0, "R3");
    push(3, 0, 1'b1, "R3");
    push(19, 0, 1'b0, "R3"); push(19, 1, 1'b1, "R3");
    push(29, 0, 1'b1, "R3"); push(29, 1, 1'b0, "R3");
    push(45, 0, 1'b0, "R3"); push(45, 1, 1'b1, "R3");
    push(55, 0, 1'b1, "R3"); push(55, 1, 1'b0, "R3");
    wait_rel(25); chk("R3", "read_act paused in shutter window", read_act, 1'b0);
    wait_rel(29); chk("R3", "ptr_rst at frame after pause", ptr_rst, 1'b1);
    wait_rel(60); end_run("R3");

    // R4 R5 R6 R9: triggered mode, aborted dummy frame, ignored late triggers
    start_run(3'b001, 0, 0, 0, 16'd2, 0, 0, "R6");
    push(3, 2, 1'b1, "R4");
    push(33, 2, 1'b0, "R5");
    push(49, 1, 1'b1, "R6");
    push(59, 0, 1'b1, "R6"); push(59, 1, 1'b0, "R6");
    push(75, 0, 1'b0, "R6"); push(75, 2, 1'b1, "R6");
    wait_rel(10); chk("R4", "dummy readout active", read_act, 1'b1);
    chk("R4", "dummy readout not valid", fval, 1'b0);
    wait_rel(28); trig_a = 1'b1;
    wait_rel(31); trig_a = 1'b0;
    wait_rel(32); chk("R5", "no pointer reset before trigger acceptance", ptr_rst, 1'b0);
    wait_rel(33); chk("R5", "pointer reset on abort", ptr_rst, 1'b1);
    chk("R5", "readout restarted", read_act, 1'b1);
    wait_rel(35); chk("R5", "aborted frame does not restart on old boundary", ptr_rst, 1'b0);
    wait_rel(48); trig_a = 1'b1;
    wait_rel(51); trig_a = 1'b0;
    wait_rel(62); trig_a = 1'b1;
    wait_rel(65); trig_a = 1'b0;
    wait_rel(95); end_run("R9");

    // R6: triggered mode with zero shutter count
    start_run(3'b001, 0, 0, 0, 16'd0, 0, 0, "R6");
    push(3, 2, 1'b1, "R6");
    push(33, 2, 1'b0, "R6");
    push(49, 0, 1'b1, "R6");
    push(65, 0, 1'b0, "R6"); push(65, 2, 1'b1, "R6");
    wait_rel(28); trig_a = 1'b1;
    wait_rel(31); trig_a = 1'b0;
    wait_rel(80); end_run("R6");

    // R7 R10: triggered without dummy frame, short pulse rejected first
    start_run(3'b010, 0, 0, 0, 16'd2, 0, 0, "R7");
    push(3, 2, 1'b1, "R7");
    push(33, 1, 1'b1, "R7"); push(33, 2, 1'b0, "R7");
    push(43, 0, 1'b1, "R7"); push(43, 1, 1'b0, "R7");
    push(59, 0, 1'b0, "R7"); push(59, 2, 1'b1, "R7");
    wait_rel(8);  trig_a = 1'b1;
    wait_rel(10); trig_a = 1'b0;
    wait_rel(20); chk("R10", "short pulse leaves block waiting", wait_trig, 1'b1);
    wait_rel(28); trig_a = 1'b1;
    wait_rel(31); trig_a = 1'b0;
    wait_rel(70); end_run("R10");

    // R11 R12 R13: input B selected, active low trigger, inverted shutter
    start_run(3'b010, 1, 1, 1, 16'd2, 1, 1, "R11");
    push(3, 2, 1'b1, "R11");
    push(33, 1, 1'b0, "R13"); push(33, 2, 1'b0, "R12");
    push(43, 0, 1'b1, "R12"); push(43, 1, 1'b1, "R13");
    push(59, 0, 1'b0, "R12"); push(59, 2, 1'b1, "R12");
    wait_rel(10); trig_a = 1'b0;
    wait_rel(13); trig_a = 1'b1;
    wait_rel(20); chk("R11", "unselected input ignored", wait_trig, 1'b1);
    wait_rel(28); trig_b = 1'b0;
    wait_rel(31); trig_b = 1'b1;
    wait_rel(70); end_run("R12");

    // R8: shutter follows sync high time
    start_run(3'b011, 0, 0, 0, 16'd0, 0, 0, "R8");
    push(3, 2, 1'b1, "R8");
    push(33, 1, 1'b1, "R8"); push(33, 2, 1'b0, "R8");
    push(43, 0, 1'b1, "R8"); push(43, 1, 1'b0, "R8");
    push(59, 0, 1'b0, "R8"); push(59, 2, 1'b1, "R8");
    wait_rel(28); trig_a = 1'b1;
    wait_rel(40); trig_a = 1'b0;
    wait_rel(43); chk("R8", "valid frame starts from line 1", ptr_rst, 1'b1);
    wait_rel(70); end_run("R8");

    // R14: reserved mode code does nothing
    start_run(3'b110, 0, 0, 0, 16'd2, 0, 0, "R14");
    wait_rel(10); trig_a = 1'b1;
    wait_rel(20); trig_a = 1'b0;
    wait_rel(40);
    chk("R14", "no readout", read_act, 1'b0);
    chk("R14", "no valid frame", fval, 1'b0);
    chk("R14", "no waiting status", wait_trig, 1'b0);
    chk("R14", "shutter inactive", shutter, 1'b0);
    end_run("R14");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", mon_checks + drv_checks,
             mon_fails + drv_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      wd_fails++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", mon_checks + drv_checks + 1,
               mon_fails + drv_fails + wd_fails);
      $finish;
    end
  end

endmodule